// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal and vertical timing of a video raster. The line and frame lengths are not fixed when the chip is built. Software loads them at run time through a small register-write port. Each direction has four lengths: the visible region, the front porch, the sync pulse and the back porch. The generator runs on the pixel clock, which is around 148.5 MHz for a 1920x1080 mode. Its outputs are active-high hsync and vsync, a display-enable, and the current pixel and line counts.

Software writes into shadow registers. The generator copies them into its working set only when one frame ends and the next begins, so a frame is never scanned with mixed settings. The block also drives a glitch-free copy of hsync, one clock late, as a status bit. A processor can poll this bit and hold back video-memory writes until the line is in sync. A typical programme is 1920/205/50/255 horizontally, which gives 2430 clocks per line, and 1080/2/55/2 vertically, which gives 1139 lines per frame.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with `wr_en` high is captured at the rising clock edge. Addresses 0, 1, 2 and 3 hold the horizontal visible, front porch, sync and back porch lengths. Addresses 4, 5, 6 and 7 hold the same four lengths for the vertical direction.
- R2: `pix_cnt` counts 0, 1, … up to the horizontal total minus one, then returns to 0. The horizontal total is the sum of the four horizontal lengths.
- R3: `line_cnt` advances by one in the cycle after `pix_cnt` wraps, holds its value within a line, and returns to 0 after the vertical total of lines.
- R4: Each line runs visible, front porch, sync, back porch, in that order. `hsync` is high only while `pix_cnt` lies in the sync interval. `vsync` is high only while `line_cnt` lies in the vertical sync interval. Both are active high.
- R5: `de` is high exactly when both `pix_cnt` and `line_cnt` lie in their visible regions.
- R6: A register write changes no output during the current frame and takes effect from the first cycle of the next frame. This holds even when the write lands in the last cycle of a frame.
- R7: `stat_hsync` equals the value `hsync` had in the previous clock cycle.
- R8: A programmed length of zero is treated as a length of one.
- R9: While reset is held, both counters are 0, and `hsync`, `vsync` and `stat_hsync` are low. The working and shadow registers take the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Timing register index |
| wr_data | input | 12 | Interval length to store |
| pix_cnt | output | 14 | Pixel position within the line |
| line_cnt | output | 14 | Line position within the frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| stat_hsync | output | 1 | Registered hsync for processor polling |

## Verification
Some properties are checked on every cycle. The pixel counter either steps by one or wraps to zero. The line counter and vsync change only at a line start. Display-enable never overlaps either sync. The status bit trails hsync by exactly one clock. The working line length changes only right after a frame end. The bench scenarios cover what a cycle-local property cannot show: that each address reaches the right interval, the exact placement of every sync and visible region, the handling of zero lengths, and the rule that a write in the last cycle of a frame still applies to the very next frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int unsigned LEN_W      = 12;
  parameter int unsigned CNT_W      = LEN_W + 2;
  parameter int unsigned NUM_SEG    = 4;
  parameter int unsigned NUM_REG    = 2 * NUM_SEG;
  parameter int unsigned REG_ADDR_W = $clog2(NUM_REG);

  typedef enum logic [1:0] {
    SEG_VISIBLE = 2'd0,
    SEG_FRONT   = 2'd1,
    SEG_SYNC    = 2'd2,
    SEG_BACK    = 2'd3
  } seg_e;

  typedef struct packed {
    logic [LEN_W-1:0] visible;
    logic [LEN_W-1:0] front;
    logic [LEN_W-1:0] sync;
    logic [LEN_W-1:0] back;
  } axis_cfg_t;

  // zero-length intervals are stretched to one (R8)
  function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] v);
    logic [CNT_W-1:0] r;
    r = (v == '0) ? CNT_W'(1) : CNT_W'(v);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] period(input axis_cfg_t c);
    return eff_len(c.visible) + eff_len(c.front) + eff_len(c.sync) + eff_len(c.back);
  endfunction

  function automatic seg_e seg_at(input axis_cfg_t c, input logic [CNT_W-1:0] pos);
    logic [CNT_W-1:0] end_vis, end_front, end_sync;
    seg_e r;
    end_vis   = eff_len(c.visible);
    end_front = end_vis + eff_len(c.front);
    end_sync  = end_front + eff_len(c.sync);
    if (pos < end_vis)        r = SEG_VISIBLE;
    else if (pos < end_front) r = SEG_FRONT;
    else if (pos < end_sync)  r = SEG_SYNC;
    else                      r = SEG_BACK;
    return r;
  endfunction
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
#(
  parameter axis_cfg_t H_INIT = '0,
  parameter axis_cfg_t V_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]      wr_data,
  input  logic                  commit,
  output axis_cfg_t             h_cfg,
  output axis_cfg_t             v_cfg
);
  function automatic logic [LEN_W-1:0] init_val(input int idx);
    axis_cfg_t c;
    logic [LEN_W-1:0] r;
    c = (idx < int'(NUM_SEG)) ? H_INIT : V_INIT;
    case (idx % int'(NUM_SEG))
      0:       r = c.visible;
      1:       r = c.front;
      2:       r = c.sync;
      default: r = c.back;
    endcase
    return r;
  endfunction

  logic [LEN_W-1:0] shadow_q [NUM_REG];
  logic [LEN_W-1:0] shadow_d [NUM_REG];
  logic [LEN_W-1:0] live_q   [NUM_REG];

  for (genvar i = 0; i < int'(NUM_REG); i++) begin : g_reg
    localparam logic [LEN_W-1:0] INIT = init_val(i);
    // a write in the commit cycle is folded in, so it reaches the next frame
    assign shadow_d[i] = (wr_en && (wr_addr == REG_ADDR_W'(i))) ? wr_data : shadow_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= INIT;
        live_q[i]   <= INIT;
      end else begin
        shadow_q[i] <= shadow_d[i];
        if (commit) live_q[i] <= shadow_d[i];
      end
    end
  end

  assign h_cfg = '{visible: live_q[0], front: live_q[1], sync: live_q[2], back: live_q[3]};
  assign v_cfg = '{visible: live_q[4], front: live_q[5], sync: live_q[6], back: live_q[7]};
endmodule

// File: rtl/rtg_axis_ctr.sv
module rtg_axis_ctr
  import rtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  axis_cfg_t        cfg,
  output logic [CNT_W-1:0] pos,
  output logic             wrap,
  output seg_e             seg
);
  logic [CNT_W-1:0] last_pos;
  logic             at_last;

  assign last_pos = period(cfg) - CNT_W'(1);
  assign at_last  = (pos == last_pos);
  assign wrap     = adv && at_last;
  assign seg      = seg_at(cfg, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (adv) pos <= at_last ? '0 : pos + CNT_W'(1);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned RST_H_VISIBLE = 1920,
  parameter int unsigned RST_H_FRONT   = 205,
  parameter int unsigned RST_H_SYNC    = 50,
  parameter int unsigned RST_H_BACK    = 255,
  parameter int unsigned RST_V_VISIBLE = 1080,
  parameter int unsigned RST_V_FRONT   = 2,
  parameter int unsigned RST_V_SYNC    = 55,
  parameter int unsigned RST_V_BACK    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      pix_cnt,
  output logic [CNT_W-1:0]      line_cnt,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  de,
  output logic                  stat_hsync
);
  localparam axis_cfg_t H_INIT = '{visible: LEN_W'(RST_H_VISIBLE), front: LEN_W'(RST_H_FRONT),
                                   sync: LEN_W'(RST_H_SYNC), back: LEN_W'(RST_H_BACK)};
  localparam axis_cfg_t V_INIT = '{visible: LEN_W'(RST_V_VISIBLE), front: LEN_W'(RST_V_FRONT),
                                   sync: LEN_W'(RST_V_SYNC), back: LEN_W'(RST_V_BACK)};

  axis_cfg_t        h_cfg, v_cfg;
  logic             line_end, frame_end;
  seg_e             h_seg, v_seg;
  logic [CNT_W-1:0] h_period;

  rtg_cfg_regs #(.H_INIT(H_INIT), .V_INIT(V_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(frame_end), .h_cfg(h_cfg), .v_cfg(v_cfg)
  );

  rtg_axis_ctr u_hctr (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .cfg(h_cfg),
    .pos(pix_cnt), .wrap(line_end), .seg(h_seg)
  );

  rtg_axis_ctr u_vctr (
    .clk(clk), .rst_n(rst_n), .adv(line_end), .cfg(v_cfg),
    .pos(line_cnt), .wrap(frame_end), .seg(v_seg)
  );

  assign h_period = period(h_cfg);
  assign hsync    = (h_seg == SEG_SYNC);
  assign vsync    = (v_seg == SEG_SYNC);
  assign de       = (h_seg == SEG_VISIBLE) && (v_seg == SEG_VISIBLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_hsync <= 1'b0;
    else        stat_hsync <= hsync;
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] pix_cnt,
  input logic [CNT_W-1:0] line_cnt,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic             stat_hsync,
  input logic             frame_end,
  input logic [CNT_W-1:0] h_period
);
  p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pix_cnt == $past(pix_cnt) + CNT_W'(1)) || (pix_cnt == '0)));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != '0) |-> $stable(line_cnt));

  p_vsync_at_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> (pix_cnt == '0));

  p_de_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  p_cfg_at_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_period) |-> $past(frame_end));

  p_stat_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_hsync == $past(hsync)));
endmodule

bind raster_timing_gen rtg_checker i_rtg_chk (
  .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
  .hsync(hsync), .vsync(vsync), .de(de), .stat_hsync(stat_hsync),
  .frame_end(frame_end), .h_period(h_period)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  import rtg_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic [REG_ADDR_W-1:0] wr_addr = '0;
  logic [LEN_W-1:0]      wr_data = '0;
  logic [CNT_W-1:0]      pix_cnt, line_cnt;
  logic                  hsync, vsync, de, stat_hsync;

  always #4 clk = ~clk;

  raster_timing_gen #(
    .RST_H_VISIBLE(6), .RST_H_FRONT(2), .RST_H_SYNC(3), .RST_H_BACK(2),
    .RST_V_VISIBLE(3), .RST_V_FRONT(1), .RST_V_SYNC(2), .RST_V_BACK(1)
  ) i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hsync(hsync), .vsync(vsync),
    .de(de), .stat_hsync(stat_hsync)
  );

  typedef struct {
    int h;
    int v;
    bit hs;
    bit vs;
    bit de;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    fails = 0;
  int    popped = 0;
  bit    started = 1'b0;
  bit    stop_mon = 1'b0;
  bit    reported = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // expected raster built segment by segment; zero lengths become one (R8)
  task automatic push_frame(input int ha, input int hf, input int hs, input int hb,
                            input int va, input int vf, input int vs, input int vb);
    int hl[4];
    int vl[4];
    bit col_sync[$];
    bit col_vis[$];
    bit row_sync[$];
    bit row_vis[$];
    hl = '{clamp(ha), clamp(hf), clamp(hs), clamp(hb)};
    vl = '{clamp(va), clamp(vf), clamp(vs), clamp(vb)};
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < hl[s]; n++) begin
        col_sync.push_back(s == 2);
        col_vis.push_back(s == 0);
      end
      for (int n = 0; n < vl[s]; n++) begin
        row_sync.push_back(s == 2);
        row_vis.push_back(s == 0);
      end
    end
    for (int y = 0; y < row_sync.size(); y++) begin
      for (int x = 0; x < col_sync.size(); x++) begin
        item_t it;
        it.h  = x;
        it.v  = y;
        it.hs = col_sync[x];
        it.vs = row_sync[y];
        it.de = col_vis[x] && row_vis[y];
        sb_q.push_back(it);
      end
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    #1;
    wr_en   = 1'b1;
    wr_addr = REG_ADDR_W'(addr);
    wr_data = LEN_W'(data);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  // monitor: pops one expected item per cycle and compares at the falling edge
  initial begin : monitor
    bit prev_hs;
    prev_hs = 1'b0;
    wait (started);
    forever begin
      @(negedge clk);
      if (stop_mon) break;
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 scoreboard underrun", 0, 1);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        popped++;
        check(int'(pix_cnt) == e.h, "R2 pixel counter", int'(pix_cnt), e.h);
        check(int'(line_cnt) == e.v, "R3 line counter", int'(line_cnt), e.v);
        check(hsync == e.hs, "R4 hsync", int'(hsync), int'(e.hs));
        check(vsync == e.vs, "R4 vsync", int'(vsync), int'(e.vs));
        check(de == e.de, "R5 display enable", int'(de), int'(e.de));
        check(stat_hsync == prev_hs, "R7 status lag", int'(stat_hsync), int'(prev_hs));
        prev_hs = e.hs;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin : driver
    // R9: reset state
    repeat (3) @(negedge clk);
    check(pix_cnt == '0, "R9 reset pixel counter", int'(pix_cnt), 0);
    check(line_cnt == '0, "R9 reset line counter", int'(line_cnt), 0);
    check(hsync == 1'b0, "R9 reset hsync", int'(hsync), 0);
    check(vsync == 1'b0, "R9 reset vsync", int'(vsync), 0);
    check(stat_hsync == 1'b0, "R9 reset status", int'(stat_hsync), 0);

    // frame 0 runs on the parameter defaults (R9)
    push_frame(6, 2, 3, 2, 3, 1, 2, 1);
    @(posedge clk);
    #1;
    rst_n   = 1'b1;
    started = 1'b1;

    // R1/R6: load all eight registers mid-frame; frame 0 must stay unchanged
    wait (popped >= 2);
    reg_write(0, 4);
    reg_write(1, 1);
    reg_write(2, 2);
    reg_write(3, 1);
    reg_write(4, 2);
    reg_write(5, 1);
    reg_write(6, 1);
    reg_write(7, 1);
    push_frame(4, 1, 2, 1, 2, 1, 1, 1);

    // R8: a zero sync length behaves as one, from frame 2
    wait (popped >= 91 + 3);
    reg_write(2, 0);
    push_frame(4, 1, 1, 1, 2, 1, 1, 1);

    // R6 boundary: write in the last cycle of frame 2 applies to frame 3
    wait (popped == 91 + 40 + 35);
    #1;
    wr_en   = 1'b1;
    wr_addr = REG_ADDR_W'(4);
    wr_data = LEN_W'(3);
    push_frame(4, 1, 1, 1, 3, 1, 1, 1);
    @(posedge clk);
    #1;
    wr_en = 1'b0;

    wait (sb_q.size() == 0);
    #1;
    stop_mon = 1'b1;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule